// File: doc/BRIEF.md
# Two-Operand Integer ALU with Equality Flag

This block is a purely combinational arithmetic and logic unit for a 32-bit integer datapath. Two operand words and a 4-bit operation code go in; a result word and a one-bit equality indication come out in the same time step, with no clock, no register and no handshake. A branch-capable datapath places it between the register read ports and the write-back or branch logic. The datapath reads the result for every supported operation. It reads the equality bit only while a subtraction is selected.

Six operations are decoded from a sparse code space: bitwise AND, OR and NOR, wrapping addition and subtraction, and a signed less-than test. The equality bit is meaningful only during subtraction. For every other code the block drives it to the unknown value, so that any consumer which samples it at the wrong time propagates X in a four-state simulation. A code outside the six decoded values drives an all-unknown result. These unknown outputs cannot be observed on a two-state simulator, so the requirements below cover only the defined outputs.

Top module: `alu32_eq`

## Requirements
- R1: With op code 4'b0000 the result is the bitwise AND of the two operands.
- R2: With op code 4'b0001 the result is the bitwise OR of the two operands.
- R3: With op code 4'b1100 the result is the bitwise NOR of the two operands.
- R4: With op code 4'b0010 the result is a + b taken modulo 2^32, and a carry out of bit 31 is dropped.
- R5: With op code 4'b0110 the result is a - b taken modulo 2^32, so a borrow wraps around.
- R6: With op code 4'b0111 the result is 32'd1 when a is less than b as signed two's-complement numbers, and 32'd0 otherwise. Bits 31..1 are always zero.
- R7: With op code 4'b0110 the equality output is 1 exactly when the two operands are identical, and 0 otherwise.
- R8: The outputs follow any change of the operands or of the op code within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand (minuend, left side of the comparison) |
| b_i | input | 32 | Second operand (subtrahend, right side of the comparison) |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| equal_o | output | 1 | Equality indication; defined only for subtraction |

## Verification
The block holds no state, so a fault inside it shows at the ports at once: the result of the very next operand pair is wrong. The bench applies random operand pairs and samples the outputs one nanosecond after each change. It adds directed cases that a random draw seldom hits: equal operands, carry and borrow wrap, and less-than comparisons of operands with opposite signs. A decode fault that swaps two operation codes, or a comparison that ignores the sign, shows up on the first such case.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;
endpackage

// File: rtl/alu32_bitwise.sv
module alu32_bitwise #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);
  // One slice per bit; the three outputs share nothing but the inputs.
  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    always_comb begin
      and_o[g] = a_i[g] & b_i[g];
      or_o[g]  = a_i[g] | b_i[g];
      nor_o[g] = ~(a_i[g] | b_i[g]);
      // R3 and R1: NOR and AND can never both be 1 in one bit
      p_nor_and_excl_r3: assert (!(and_o[g] && nor_o[g]));
      // R2: exactly one of OR and NOR is set in every bit
      p_or_nor_cover_r2: assert (or_o[g] ^ nor_o[g]);
    end
  end
endmodule

// File: rtl/alu32_arith.sv
module alu32_arith #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] diff_o,
  output logic [WIDTH-1:0] slt_o,
  output logic             zero_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] sub_ext;
  logic           ovf;

  always_comb begin
    sum_o   = a_i + b_i;
    sub_ext = {1'b0, a_i} + {1'b0, ~b_i} + {{WIDTH{1'b0}}, 1'b1};
    diff_o  = sub_ext[MSB:0];
    ovf     = (a_i[MSB] ^ b_i[MSB]) & (a_i[MSB] ^ diff_o[MSB]);
    slt_o   = '0;
    slt_o[0] = diff_o[MSB] ^ ovf;
    zero_o  = (diff_o == '0);

    // R4: taking b back off the sum gives a again
    p_add_wrap_r4: assert (WIDTH'(sum_o - b_i) == a_i);
    // R5: adding b back onto the difference gives a again
    p_sub_wrap_r5: assert (WIDTH'(diff_o + b_i) == a_i);
    // R6: the less-than result is 0 or 1 only
    p_slt_bin_r6: assert (slt_o[MSB:1] == '0);
    // R6: when the signs differ, the negative operand is the smaller
    p_slt_sign_r6: assert ((a_i[MSB] == b_i[MSB]) || (slt_o[0] == a_i[MSB]));
    // R7: the zero test on the difference agrees with direct comparison
    p_eq_match_r7: assert (zero_o == (a_i == b_i));
  end
endmodule

// File: rtl/alu32_eq.sv
module alu32_eq
  import alu32_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             equal_o
);
  logic [WIDTH-1:0] and_w, or_w, nor_w;
  logic [WIDTH-1:0] sum_w, diff_w, slt_w;
  logic             zero_w;

  alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .or_o  (or_w),
    .nor_o (nor_w)
  );

  alu32_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_w),
    .diff_o (diff_w),
    .slt_o  (slt_w),
    .zero_o (zero_w)
  );

  // R8: output select is combinational, no storage on the path
  always_comb begin
    equal_o = 1'bx;
    case (alu_op_e'(op_i))
      OP_AND:  result_o = and_w;
      OP_OR:   result_o = or_w;
      OP_NOR:  result_o = nor_w;
      OP_ADD:  result_o = sum_w;
      OP_SUB: begin
        result_o = diff_w;
        equal_o  = zero_w;
      end
      OP_SLT:  result_o = slt_w;
      default: result_o = 'x;
    endcase
  end
endmodule

// File: tb/sim_alu32_eq.sv
module sim_alu32_eq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] result;
  logic        equal;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  alu32_eq u0 (.a_i(a), .b_i(b), .op_i(op), .result_o(result), .equal_o(equal));

  function automatic logic [31:0] exp_res(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    case (o)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b1100: return ~(x | y);
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b1100: return "R3";
      4'b0010: return "R4";
      4'b0110: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive away from the rising edge, sample 1 ns later.
  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    #1;
    chk(tag_of(o), result, exp_res(o, x, y));
    if (o == 4'b0110) chk("R7", {31'd0, equal}, {31'd0, x == y});
  endtask

  task automatic all_ops(input logic [31:0] x, input logic [31:0] y);
    apply(4'b0000, x, y);
    apply(4'b0001, x, y);
    apply(4'b1100, x, y);
    apply(4'b0010, x, y);
    apply(4'b0110, x, y);
    apply(4'b0111, x, y);
  endtask

  initial begin
    a = '0; b = '0; op = 4'b0000;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 idle zero", result, 32'd0);
    // directed corner cases
    all_ops(32'hFFFF_FFFF, 32'h0000_0001);  // R4 carry wrap
    all_ops(32'h0000_0000, 32'h0000_0001);  // R5 borrow wrap
    all_ops(32'h1234_5678, 32'h1234_5678);  // R7 equal operands
    all_ops(32'h8000_0000, 32'h7FFF_FFFF);  // R6 sign differs, a negative
    all_ops(32'h7FFF_FFFF, 32'h8000_0000);  // R6 sign differs, b negative
    all_ops(32'hFFFF_FFFE, 32'hFFFF_FFFF);  // R6 both negative
    all_ops(32'hA5A5_A5A5, 32'h5A5A_5A5A);  // R1 R2 R3 disjoint bits
    // R8: change inputs between edges and see the output move at once
    @(posedge clk);
    #3;
    op = 4'b0010; a = 32'd5; b = 32'd6;
    #1;
    chk("R8 no-clock add", result, 32'd11);
    a = 32'd100;
    #1;
    chk("R8 operand change", result, 32'd106);
    op = 4'b0110; b = 32'd100;
    #1;
    chk("R8 op change", result, 32'd0);
    chk("R8 equal follows", {31'd0, equal}, 32'd1);
    // constrained random with a fixed seed
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = ($urandom() % 8 == 0) ? x : $urandom();
      if ($urandom() % 4 == 0) y[31] = ~x[31];
      all_ops(x, y);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule